// File: doc/BRIEF.md
# Byte-Immediate Accumulator Execution Unit

This block is a one-register execution unit. A single 32-bit accumulator is changed by 16-bit instructions. Each instruction holds an opcode byte and an operand byte. The operand byte is either an immediate or an address into a 256-word internal data memory. An instruction is accepted through a valid/ready port and takes effect in the same clock cycle.

No immediate is wider than eight bits. A full 32-bit constant is therefore built in steps. The first step loads the top byte. Each following step shifts left by eight and then ORs in the next byte. Values larger than a byte that sit in the data memory can be added to the accumulator directly.

The data memory is filled through its own write port. Reads from it are combinational. Opcodes that are not defined do not change the accumulator. They raise an illegal flag for one cycle.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_ni` is low, `acc_o` is 0, `illegal_o` is 0 and `insn_ready_o` is 0. After the first rising clock edge following reset release, `insn_ready_o` is 1.
- R2: An instruction is accepted at a rising edge where `insn_valid_i` and `insn_ready_o` are both high. The opcode is `insn_i[15:8]` and the operand is `insn_i[7:0]`. The result shows on `acc_o` right after that edge.
- R3: Opcode 0x01 sets the accumulator to the operand zero-extended to 32 bits.
- R4: Opcode 0x02 with an operand below 32 shifts the accumulator left by the operand and fills with zeros.
- R5: Opcode 0x02 with an operand of 32 or more sets the accumulator to 0.
- R6: Opcode 0x03 ORs the zero-extended operand into the accumulator.
- R7: Opcode 0x04 adds the memory word at address operand to the accumulator, modulo 2^32.
- R8: When `dmem_we_i` is high at a rising edge, `dmem_wdata_i` is stored at `dmem_addr_i`. An add accepted at that same edge to that same address uses the old contents.
- R9: Any other opcode leaves the accumulator unchanged. It drives `illegal_o` high for exactly the cycle after the edge that accepted it. `illegal_o` is low otherwise.
- R10: At an edge with `insn_valid_i` low, the accumulator keeps its value whatever `insn_i` carries.
- R11: The sequence load 0x12, shift 8, OR 0x34, shift 8, OR 0x56, shift 8, OR 0x78 leaves 0x12345678 in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | Instruction present |
| insn_i | input | 16 | Opcode in [15:8], operand in [7:0] |
| insn_ready_o | output | 1 | Unit can accept an instruction |
| dmem_we_i | input | 1 | Data memory write enable |
| dmem_addr_i | input | 8 | Data memory write address |
| dmem_wdata_i | input | 32 | Data memory write word |
| acc_o | output | 32 | Accumulator value |
| illegal_o | output | 1 | One-cycle flag for an undefined opcode |

## Verification
The assertions assume that `insn_valid_i`, `insn_i` and the memory write inputs are stable at each rising edge. They also assume that every memory word read by an add was written at some earlier point, so the add never sees undefined contents.

The stimulus meets these assumptions in two ways. It changes inputs only on falling edges. It writes all 256 words before any random add is issued.

Random instructions mix every defined opcode with undefined ones. The shift operands are biased so that both sides of the 32 boundary are covered. Directed cases add three more situations:
- a memory write and an add to the same address on the same edge,
- idle cycles with noise on the instruction bus,
- the seven-step build of a constant.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned OPC_W  = 8;
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned INSN_W = OPC_W + IMM_W;
  localparam int unsigned MEM_DEPTH = 2 ** IMM_W;
  localparam int unsigned ADDR_W = $clog2(MEM_DEPTH);
  localparam int unsigned SH_W   = $clog2(ACC_W);

  localparam logic [OPC_W-1:0] OPC_LOAD = 8'h01;
  localparam logic [OPC_W-1:0] OPC_SHL  = 8'h02;
  localparam logic [OPC_W-1:0] OPC_OR   = 8'h03;
  localparam logic [OPC_W-1:0] OPC_ADD  = 8'h04;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_LOAD,
    OP_SHL,
    OP_OR,
    OP_ADD
  } op_e;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output op_e              op_o,
  output logic             illegal_o
);
  always_comb begin
    op_o      = OP_NOP;
    illegal_o = 1'b0;
    unique case (opcode_i)
      OPC_LOAD: op_o = OP_LOAD;
      OPC_SHL:  op_o = OP_SHL;
      OPC_OR:   op_o = OP_OR;
      OPC_ADD:  op_o = OP_ADD;
      default:  illegal_o = 1'b1;
    endcase
  end

  // R9
  always_comb begin
    illegal_is_nop_chk: assert (!illegal_o || op_o == OP_NOP);
  end
endmodule

// File: rtl/acc_dmem.sv
module acc_dmem
  import acc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ACC_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [ACC_W-1:0]  rdata_o
);
  logic [ACC_W-1:0] mem_q [MEM_DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // The read path has no register, so an add sees the value from before the edge
  assign rdata_o = mem_q[raddr_i];

  // R8
  mem_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
(
  input  op_e              op_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [ACC_W-1:0] mem_rdata_i,
  output logic [ACC_W-1:0] acc_nxt_o
);
  localparam logic [IMM_W-1:0] SH_LIMIT = IMM_W'(ACC_W);

  logic [ACC_W-1:0] imm_zx;
  logic [ACC_W-1:0] shl_res;

  assign imm_zx  = {{(ACC_W-IMM_W){1'b0}}, imm_i};
  assign shl_res = (imm_i >= SH_LIMIT) ? '0 : (acc_i << imm_i[SH_W-1:0]);

  always_comb begin
    unique case (op_i)
      OP_LOAD: acc_nxt_o = imm_zx;
      OP_SHL:  acc_nxt_o = shl_res;
      OP_OR:   acc_nxt_o = acc_i | imm_zx;
      OP_ADD:  acc_nxt_o = acc_i + mem_rdata_i;
      default: acc_nxt_o = acc_i;
    endcase
  end

  // R6
  always_comb begin
    if (op_i == OP_OR) or_keeps_bits_chk: assert ((acc_nxt_o & acc_i) == acc_i);
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              insn_ready_o,
  input  logic              dmem_we_i,
  input  logic [ADDR_W-1:0] dmem_addr_i,
  input  logic [ACC_W-1:0]  dmem_wdata_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              illegal_o
);
  logic [OPC_W-1:0] opcode;
  logic [IMM_W-1:0] imm;
  op_e              op;
  logic             dec_illegal;
  logic [ACC_W-1:0] mem_rdata;
  logic [ACC_W-1:0] acc_nxt;
  logic [ACC_W-1:0] acc_q;
  logic             ready_q;
  logic             illegal_q;
  logic             fire;

  assign opcode = insn_i[INSN_W-1:IMM_W];
  assign imm    = insn_i[IMM_W-1:0];
  assign fire   = insn_valid_i & ready_q;

  acc_decode i_decode (
    .opcode_i  (opcode),
    .op_o      (op),
    .illegal_o (dec_illegal)
  );

  acc_dmem i_dmem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dmem_we_i),
    .waddr_i (dmem_addr_i),
    .wdata_i (dmem_wdata_i),
    .raddr_i (imm[ADDR_W-1:0]),
    .rdata_o (mem_rdata)
  );

  acc_alu i_alu (
    .op_i        (op),
    .acc_i       (acc_q),
    .imm_i       (imm),
    .mem_rdata_i (mem_rdata),
    .acc_nxt_o   (acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q   <= 1'b0;
      acc_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      illegal_q <= fire & dec_illegal;
      if (fire) acc_q <= acc_nxt;
    end
  end

  assign insn_ready_o = ready_q;
  assign acc_o        = acc_q;
  assign illegal_o    = illegal_q;

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |=> $stable(acc_o) && !illegal_o);

  // R9
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && dec_illegal) |=> $stable(acc_o) && illegal_o);

  // R9
  illegal_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(fire && dec_illegal));

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && opcode == OPC_LOAD) |=> acc_o == {{(ACC_W-IMM_W){1'b0}}, $past(imm)});

  // R5
  shift_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && opcode == OPC_SHL && imm >= IMM_W'(ACC_W)) |=> acc_o == '0);

  // R7
  add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && opcode == OPC_ADD) |=> acc_o == $past(acc_o + mem_rdata));

  // R1
  always_comb begin
    if (!rst_ni) reset_chk: assert (acc_o == '0 && !illegal_o && !insn_ready_o);
  end
endmodule

// File: tb/test_acc_exec_unit.sv
module test_acc_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] insn = '0;
  logic        ready;
  logic        we = 1'b0;
  logic [7:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] acc;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_acc = '0;
  logic [31:0] m_mem [256];

  always #10 clk = ~clk;

  acc_exec_unit i_acc_exec_unit (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .insn_valid_i (valid),
    .insn_i       (insn),
    .insn_ready_o (ready),
    .dmem_we_i    (we),
    .dmem_addr_i  (waddr),
    .dmem_wdata_i (wdata),
    .acc_o        (acc),
    .illegal_o    (illegal)
  );

  function automatic logic [31:0] model(logic [7:0] opc, logic [7:0] imm,
                                        logic [31:0] a, logic [31:0] m);
    case (opc)
      8'h01: return {24'h0, imm};
      8'h02: return (imm >= 8'd32) ? 32'h0 : (a << imm);
      8'h03: return a | {24'h0, imm};
      8'h04: return a + m;
      default: return a;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] opc, logic [7:0] imm);
    case (opc)
      8'h01: return "R3";
      8'h02: return (imm >= 8'd32) ? "R5" : "R4";
      8'h03: return "R6";
      8'h04: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mem_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
    m_mem[a] = d;
  endtask

  // R2: issue one instruction, then sample just after the accepting edge
  task automatic issue(logic [7:0] opc, logic [7:0] imm);
    logic [31:0] exp;
    logic        ill;
    @(negedge clk);
    valid = 1'b1; insn = {opc, imm};
    exp = model(opc, imm, m_acc, m_mem[imm]);
    ill = !(opc inside {8'h01, 8'h02, 8'h03, 8'h04});
    @(posedge clk); #1;
    valid = 1'b0;
    m_acc = exp;
    check(req_of(opc, imm), acc, exp);
    check(ill ? "R9" : "R2", {31'h0, illegal}, {31'h0, ill});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] old;
    void'($urandom(32'd4242));

    // R1 reset state
    #35;
    check("R1", acc, 32'h0);
    check("R1", {31'h0, illegal}, 32'h0);
    check("R1", {31'h0, ready}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {31'h0, ready}, 32'h1);

    // R11 build a wide constant from bytes
    issue(8'h01, 8'h12);
    issue(8'h02, 8'd8);  issue(8'h03, 8'h34);
    issue(8'h02, 8'd8);  issue(8'h03, 8'h56);
    issue(8'h02, 8'd8);  issue(8'h03, 8'h78);
    check("R11", acc, 32'h12345678);

    // R8 fill memory
    for (int i = 0; i < 256; i++) mem_write(8'(i), $urandom());

    // R5 shift boundaries
    issue(8'h01, 8'hFF); issue(8'h02, 8'd31);
    issue(8'h01, 8'hFF); issue(8'h02, 8'd32);
    issue(8'h01, 8'h01); issue(8'h02, 8'd255);

    // R7 wraparound
    mem_write(8'h10, 32'hFFFF_FFFF);
    issue(8'h01, 8'h02); issue(8'h04, 8'h10);
    check("R7", acc, 32'h1);

    // R9 undefined opcodes, back to back and then followed by a legal one
    issue(8'h00, 8'h55); issue(8'h05, 8'hAA); issue(8'hFF, 8'h00);
    issue(8'h03, 8'h80);

    // R8 write and add to the same address on one edge
    mem_write(8'h20, 32'h0000_0100);
    issue(8'h01, 8'h05);
    @(negedge clk);
    we = 1'b1; waddr = 8'h20; wdata = 32'h0000_9000;
    valid = 1'b1; insn = {8'h04, 8'h20};
    @(posedge clk); #1;
    we = 1'b0; valid = 1'b0;
    m_acc = m_acc + 32'h100; m_mem[8'h20] = 32'h0000_9000;
    check("R8", acc, 32'h105);
    issue(8'h04, 8'h20);
    check("R8", acc, 32'h9105);

    // R10 noise on the instruction bus while invalid
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      valid = 1'b0; insn = 16'($urandom());
      old = m_acc;
      @(posedge clk); #1;
      check("R10", acc, old);
      check("R10", {31'h0, illegal}, 32'h0);
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [7:0] opc, imm;
      sel = $urandom_range(0, 9);
      imm = 8'($urandom());
      case (sel)
        0, 1: opc = 8'h01;
        2, 3: begin opc = 8'h02; if ($urandom_range(0, 3) != 0) imm = 8'($urandom_range(0, 40)); end
        4, 5: opc = 8'h03;
        6, 7: opc = 8'h04;
        default: opc = 8'($urandom());
      endcase
      issue(opc, imm);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule